// File: doc/BRIEF.md
# Receive Frame Queue with Interrupt Flags

This block is a receive-only queue for a CAN-style controller. Frames that passed acceptance filtering elsewhere are written into it with their payload and an attribute word, such as the index of the filter that matched. The CPU side always sees the oldest unread frame and its attributes at a fixed head port.

The CPU takes the head frame by clearing the frames-available flag. No separate read strobe exists. Two sticky status flags sit beside that flag. One warns that the queue is almost full, and the other records that a frame was lost. Each flag has a mask bit, and each drives its own interrupt line. An enable input turns the whole queue on. While it is low the queue is flushed and takes no frames.

Top module: `rx_frame_queue`

## Requirements
- R1: After reset, all three flags and all three interrupt outputs are low, and head_data and head_attr are zero.
- R2: While enable is low, writes are ignored: the queue is emptied and all three flags read low.
- R3: The queue holds up to DEPTH (6) frames. Frames leave the head in the order they were written.
- R4: flag_avail is high exactly while at least one unread frame is queued. When it is low, head_data and head_attr read zero.
- R5: A pulse on clr_avail removes the head frame, and the next frame appears at the head in the following cycle. A clr_avail pulse while the queue is empty has no effect.
- R6: flag_warn sets only when a stored arrival raises the unread count from 4 to 5 (DEPTH-2 to DEPTH-1). It then stays set until clr_warn is pulsed.
- R7: flag_ovf sets when a frame offered with wr_taken low is dropped because all DEPTH entries are full. It then stays set until clr_ovf is pulsed.
- R8: A frame offered with wr_taken high is not stored. It never sets flag_ovf, even while the queue is full.
- R9: Clearing any one flag leaves the other two flags unchanged.
- R10: Each interrupt output (irq_avail, irq_warn, irq_ovf) is high exactly when its flag and its mask bit are both high.
- R11: A pop and an arrival in the same cycle on a full queue store the new frame at the tail and do not set flag_ovf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Queue enable; low flushes the queue and holds all flags low |
| wr_valid | input | 1 | An incoming frame is offered this cycle |
| wr_taken | input | 1 | The offered frame was captured by a mailbox instead |
| wr_data | input | DATA_W | Payload of the offered frame |
| wr_attr | input | ATTR_W | Attributes of the offered frame |
| clr_avail | input | 1 | Clear strobe for flag_avail; pops the head frame |
| clr_warn | input | 1 | Clear strobe for flag_warn |
| clr_ovf | input | 1 | Clear strobe for flag_ovf |
| mask_avail | input | 1 | Interrupt mask for flag_avail |
| mask_warn | input | 1 | Interrupt mask for flag_warn |
| mask_ovf | input | 1 | Interrupt mask for flag_ovf |
| head_data | output | DATA_W | Payload of the oldest frame; zero when the queue is empty |
| head_attr | output | ATTR_W | Attributes of the oldest frame; zero when the queue is empty |
| flag_avail | output | 1 | At least one frame is queued |
| flag_warn | output | 1 | Sticky almost-full warning |
| flag_ovf | output | 1 | Sticky overflow: a frame was dropped |
| irq_avail | output | 1 | flag_avail AND mask_avail |
| irq_warn | output | 1 | flag_warn AND mask_warn |
| irq_ovf | output | 1 | flag_ovf AND mask_ovf |

## Verification
The bench fills the queue past the warning level and past full. A design that compared against the count without requiring a rising arrival would raise the warning again while the queue drains through 5. One that counted the mailbox-captured frame as a loss would set overflow with the queue full.

The bench pops and writes in the same cycle on a full queue. A design that checked fullness before the pop would drop that frame and flag an overflow. It also pops an empty queue, which would corrupt the pointers if that pop were not ignored.

It clears each sticky flag while the others are set. This catches a clear strobe that disturbs another flag. It also shows that masks gate the interrupt lines and leave the flags alone.

// File: rtl/rx_frame_queue.sv
module rx_frame_queue #(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 32,
  parameter int ATTR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_valid,
  input  logic              wr_taken,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic              clr_avail,
  input  logic              clr_warn,
  input  logic              clr_ovf,
  input  logic              mask_avail,
  input  logic              mask_warn,
  input  logic              mask_ovf,
  output logic [DATA_W-1:0] head_data,
  output logic [ATTR_W-1:0] head_attr,
  output logic              flag_avail,
  output logic              flag_warn,
  output logic              flag_ovf,
  output logic              irq_avail,
  output logic              irq_warn,
  output logic              irq_ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DATA_W + ATTR_W;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] WARN_PRE = CW'(DEPTH - 2);
  localparam logic [PW-1:0] LAST_IX  = PW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  wire offered = enable && wr_valid && !wr_taken;
  wire pop     = enable && clr_avail && (count != '0);
  wire full    = (count == FULL_CNT);
  wire push    = offered && (!full || pop);
  wire drop    = offered && full && !pop;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {wr_attr, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      count     <= '0;
      flag_warn <= 1'b0;
      flag_ovf  <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_IX) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_IX) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (push && !pop && count == WARN_PRE) flag_warn <= 1'b1;
      else if (clr_warn)                     flag_warn <= 1'b0;
      if (drop)         flag_ovf <= 1'b1;
      else if (clr_ovf) flag_ovf <= 1'b0;
    end
  end

  assign flag_avail = (count != '0);
  assign head_data  = flag_avail ? mem[rd_ptr][DATA_W-1:0] : '0;
  assign head_attr  = flag_avail ? mem[rd_ptr][EW-1:DATA_W] : '0;
  assign irq_avail  = flag_avail & mask_avail;
  assign irq_warn   = flag_warn & mask_warn;
  assign irq_ovf    = flag_ovf & mask_ovf;

  p_capacity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count == '0 && !flag_warn && !flag_ovf));
  p_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clr_avail && count != '0 && !push) |=> count == $past(count) - 1'b1);
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && count == '0 && !wr_valid) |=> count == '0);
  p_warn_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $rose(flag_warn)) |-> ($past(count) == WARN_PRE && count == WARN_PRE + 1'b1));
  p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wr_valid && !wr_taken && full && !clr_avail) |=> flag_ovf);
  p_no_ovf_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_ovf && (!wr_valid || wr_taken)) |=> !flag_ovf);
  p_full_swap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && full && clr_avail && wr_valid && !wr_taken && !flag_ovf && !clr_ovf)
      |=> (count == FULL_CNT && !flag_ovf));
endmodule

// File: tb/rx_frame_queue_tb_top.sv
module rx_frame_queue_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, wr_valid = 1'b0, wr_taken = 1'b0;
  logic [31:0] wr_data = '0;
  logic [6:0] wr_attr = '0;
  logic clr_avail = 1'b0, clr_warn = 1'b0, clr_ovf = 1'b0;
  logic mask_avail = 1'b1, mask_warn = 1'b1, mask_ovf = 1'b1;
  logic [31:0] head_data;
  logic [6:0] head_attr;
  logic flag_avail, flag_warn, flag_ovf, irq_avail, irq_warn, irq_ovf;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_frame_queue dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_valid(wr_valid), .wr_taken(wr_taken),
    .wr_data(wr_data), .wr_attr(wr_attr), .clr_avail(clr_avail), .clr_warn(clr_warn),
    .clr_ovf(clr_ovf), .mask_avail(mask_avail), .mask_warn(mask_warn), .mask_ovf(mask_ovf),
    .head_data(head_data), .head_attr(head_attr), .flag_avail(flag_avail),
    .flag_warn(flag_warn), .flag_ovf(flag_ovf), .irq_avail(irq_avail),
    .irq_warn(irq_warn), .irq_ovf(irq_ovf));

  // ctl {wr_valid, wr_taken, clr_avail, clr_warn, clr_ovf}, byte in, flags {avail,warn,ovf}, head byte
  localparam int NV = 21;
  localparam logic [23:0] VEC [NV] = '{
    {5'b10000, 8'h11, 3'b100, 8'h11},  // R3 first write
    {5'b10000, 8'h22, 3'b100, 8'h11},
    {5'b10000, 8'h33, 3'b100, 8'h11},
    {5'b10000, 8'h44, 3'b100, 8'h11},
    {5'b10000, 8'h55, 3'b110, 8'h11},  // R6 4->5
    {5'b10000, 8'h66, 3'b110, 8'h11},  // R3 full
    {5'b10000, 8'h77, 3'b111, 8'h11},  // R7 drop
    {5'b00001, 8'h00, 3'b110, 8'h11},  // R9 clear ovf only
    {5'b11000, 8'h88, 3'b110, 8'h11},  // R8 taken elsewhere
    {5'b10100, 8'h99, 3'b110, 8'h22},  // R11 pop+write on full
    {5'b00010, 8'h00, 3'b100, 8'h22},  // R9 clear warn only
    {5'b00100, 8'h00, 3'b100, 8'h33},  // R5 pop
    {5'b00100, 8'h00, 3'b100, 8'h44},
    {5'b10000, 8'hAA, 3'b110, 8'h44},  // R6 rises again
    {5'b00100, 8'h00, 3'b110, 8'h55},  // R6 no effect going down
    {5'b00100, 8'h00, 3'b110, 8'h66},
    {5'b00100, 8'h00, 3'b110, 8'h99},  // R11 frame kept in order
    {5'b00100, 8'h00, 3'b110, 8'hAA},
    {5'b00100, 8'h00, 3'b010, 8'h00},  // R4 empty
    {5'b00100, 8'h00, 3'b010, 8'h00},  // R5 pop on empty
    {5'b00010, 8'h00, 3'b000, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    wr_valid = 1'b0; wr_taken = 1'b0; clr_avail = 1'b0; clr_warn = 1'b0; clr_ovf = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({flag_avail, flag_warn, flag_ovf, irq_avail, irq_warn, irq_ovf} == 6'b0, "R1 flags",
        {flag_avail, flag_warn, flag_ovf}, 0);
    chk(head_data == 0 && head_attr == 0, "R1 head", head_data, 0);
    rst_n = 1'b1;

    // R2: disabled queue ignores writes
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 32'h5A; wr_attr = 7'h5A;
    step();
    chk(!flag_avail && !flag_warn && !flag_ovf, "R2 write ignored", flag_avail, 0);
    @(negedge clk);
    idle_inputs();
    enable = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wr_valid, wr_taken, clr_avail, clr_warn, clr_ovf} = VEC[i][23:19];
      wr_data = {24'h0, VEC[i][18:11]};
      wr_attr = VEC[i][17:11];
      step();
      chk({flag_avail, flag_warn, flag_ovf} == VEC[i][10:8], $sformatf("R6/R7/R9 flags v%0d", i),
          {flag_avail, flag_warn, flag_ovf}, VEC[i][10:8]);
      chk(head_data == {24'h0, VEC[i][7:0]} && head_attr == VEC[i][6:0],
          $sformatf("R3/R4/R5 head v%0d", i), head_data, VEC[i][7:0]);
      chk({irq_avail, irq_warn, irq_ovf} == VEC[i][10:8], $sformatf("R10 irq v%0d", i),
          {irq_avail, irq_warn, irq_ovf}, VEC[i][10:8]);
      @(negedge clk);
      idle_inputs();
    end

    // R10: masks gate interrupts, flags unaffected; build warn+ovf state
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_data = 32'(i); wr_attr = 7'(i);
    end
    @(negedge clk);
    idle_inputs();
    mask_avail = 1'b0; mask_warn = 1'b0; mask_ovf = 1'b0;
    #1;
    chk({flag_avail, flag_warn, flag_ovf} == 3'b111, "R10 flags kept", {flag_avail, flag_warn, flag_ovf}, 3'b111);
    chk({irq_avail, irq_warn, irq_ovf} == 3'b000, "R10 masked", {irq_avail, irq_warn, irq_ovf}, 0);
    mask_warn = 1'b1;
    #1;
    chk({irq_avail, irq_warn, irq_ovf} == 3'b010, "R10 single mask", {irq_avail, irq_warn, irq_ovf}, 3'b010);

    // R9: clearing avail (pop) leaves sticky flags
    @(negedge clk);
    clr_avail = 1'b1;
    step();
    chk(flag_warn && flag_ovf && head_data == 32'd1, "R9 pop keeps warn/ovf", {flag_warn, flag_ovf, head_data[7:0]}, 10'h301);

    // R2: dropping enable flushes queue and flags
    @(negedge clk);
    idle_inputs();
    enable = 1'b0;
    step();
    chk({flag_avail, flag_warn, flag_ovf} == 3'b000 && head_data == 0, "R2 disable flush",
        {flag_avail, flag_warn, flag_ovf}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule